// File: doc/BRIEF.md
# Three-Byte Window Hash Unit

This block sits at the front of a dictionary-based byte compressor. It receives a byte stream one byte per enabled clock, holds the three most recent bytes in a short sliding window, and turns each full window into a 12-bit index. A downstream dictionary table uses that index to look up an earlier position in the stream. The three window bytes are also exposed, so that a later stage can compare them with candidate bytes.

The index comes from a fixed multiplicative hash. The oldest window byte is shifted up by eight bits and the middle byte by four, and both are XOR-folded with the newest byte into a 16-bit value. That value is multiplied by 40543 at 32-bit width, and bits [15:4] of the product form the index. The hash sits in its own register stage behind the window. Each index therefore describes the window as it stood one enabled clock earlier. A window-full flag and an index-valid flag tell consumers when each output carries meaningful data.

Top module: `trigram_hash_unit`

## Requirements
- R1: On each rising clock edge with `en` high and `rst` low, `byte_in` moves into `newer_byte`, the previous `newer_byte` moves into `middle_byte`, and the previous `middle_byte` moves into `older_byte`.
- R2: `window_full` is low until three bytes have been accepted since the last reset, and it rises at the edge that accepts the third byte.
- R3: At an enabled edge, `index_valid` takes the value `window_full` had just before that edge, and `table_index` takes the hash of the three window bytes held just before that edge.
- R4: The index is ((((older << 8) XOR (middle << 4) XOR newer) × 40543) >> 4) AND 0xFFF, where older is the byte that entered the stream first. The result lies in the range 0 to 4095.
- R5: The product is formed at 32 bits, so for any byte values, including 0xFF in every slot, no product bit that feeds index bits [15:4] is lost.
- R6: A synchronous active-high `rst` clears all three window bytes, `window_full`, `table_index` and `index_valid` at the next rising edge, whatever the value of `en`.
- R7: At an edge with `en` low, the window bytes, `window_full` and `table_index` hold their values, and `index_valid` goes low.
- R8: A reset in the middle of a stream restarts the fill count, so three new bytes are needed before `window_full` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Accept `byte_in` and advance both stages |
| byte_in | input | 8 | Incoming stream byte |
| newer_byte | output | 8 | Most recently accepted byte |
| middle_byte | output | 8 | Byte accepted one step before the newest |
| older_byte | output | 8 | Earliest byte still in the window |
| window_full | output | 1 | Three bytes have been accepted since reset |
| table_index | output | 12 | Hash of the window as it stood before the last enabled edge |
| index_valid | output | 1 | `table_index` was computed from a full window at the last edge, and that edge was enabled |

## Verification
The hardest case is the interaction between the one-cycle hash lag and interruptions of the stream. An enable gap must drop `index_valid` while the index holds, and the first index after the gap must still describe the window from before the gap. A reset two bytes into a stream must restart filling, with no stale valid index showing up afterwards. The stimulus interleaves enable gaps of one and several cycles into a run of bytes and issues a reset mid-fill. It also feeds runs of 0xFF and other high-value bytes so that the upper product bits are exercised. A cycle-accurate model of both stages, held in the bench, predicts every output after every edge.

// File: rtl/trihash_pkg.sv
package trihash_pkg;
    localparam int BYTE_W = 8;
    localparam int WIN_N  = 3;
    localparam int IDX_W  = 12;
    localparam int MULT   = 40543;
    localparam int PROD_W = 32;
    localparam int HSHIFT = 4;
    localparam int MIX_W  = 2 * BYTE_W;
    localparam int CNT_W  = $clog2(WIN_N + 1);

    typedef logic [BYTE_W-1:0] byte_t;

    // slot[0] holds the newest byte, slot[WIN_N-1] the oldest
    typedef struct packed {
        byte_t [WIN_N-1:0] slot;
        logic [CNT_W-1:0]  fill;
        logic              full;
    } win_state_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
    } hash_state_t;
endpackage

// File: rtl/tri_byte_window.sv
module tri_byte_window
    import trihash_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  byte_t             din,
    output byte_t [WIN_N-1:0] slots,
    output logic              full
);
    win_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) begin
            s_d = '0;
        end else if (en) begin
            s_d.slot[0] = din;
            for (int i = 1; i < WIN_N; i++) begin
                s_d.slot[i] = s_q.slot[i-1];
            end
            if (s_q.fill != CNT_W'(WIN_N)) begin
                s_d.fill = s_q.fill + 1'b1;
            end
            s_d.full = (s_d.fill == CNT_W'(WIN_N));
        end
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign slots = s_q.slot;
    assign full  = s_q.full;

    // R1: every slot takes the value of its younger neighbour
    a_r1_shift_order: assert property (@(posedge clk) disable iff (rst)
        en |=> (s_q.slot[1] == $past(s_q.slot[0]) && s_q.slot[2] == $past(s_q.slot[1])));

    // R7: nothing moves while disabled
    a_r7_window_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(s_q.slot) && $stable(s_q.full)));

    // R6: reset empties the window
    a_r6_window_clear: assert property (@(posedge clk)
        rst |=> (s_q.slot == '0 && !s_q.full));

    // R2: the full flag never drops without a reset
    a_r2_full_sticky: assert property (@(posedge clk) disable iff (rst)
        s_q.full |=> s_q.full);
endmodule

// File: rtl/tri_hash_stage.sv
module tri_hash_stage
    import trihash_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  byte_t            b_old,
    input  byte_t            b_mid,
    input  byte_t            b_new,
    input  logic             win_full,
    output logic [IDX_W-1:0] idx,
    output logic             idx_vld
);
    hash_state_t      h_d, h_q;
    logic [MIX_W-1:0]  mix;
    logic [PROD_W-1:0] prod;

    always_comb begin
        mix  = {b_old, {BYTE_W{1'b0}}}
             ^ (MIX_W'(b_mid) << (BYTE_W / 2))
             ^ MIX_W'(b_new);
        prod = PROD_W'(mix) * PROD_W'(MULT);
        h_d  = h_q;
        if (rst) begin
            h_d = '0;
        end else if (en) begin
            h_d.idx = prod[HSHIFT +: IDX_W];
            h_d.vld = win_full;
        end else begin
            h_d.vld = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        h_q <= h_d;
    end

    assign idx     = h_q.idx;
    assign idx_vld = h_q.vld;

    // R5: the product keeps every bit of mix times the multiplier
    always_comb begin
        a_r5_full_product: assert (prod / PROD_W'(MULT) == PROD_W'(mix));
    end

    // R3: valid follows the window flag one enabled edge later
    a_r3_valid_lag: assert property (@(posedge clk) disable iff (rst)
        en |=> (h_q.vld == $past(win_full)));

    // R7: a disabled edge drops valid and keeps the index
    a_r7_valid_drop: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!h_q.vld && $stable(h_q.idx)));
endmodule

// File: rtl/trigram_hash_unit.sv
module trigram_hash_unit
    import trihash_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        en,
    input  logic [7:0]  byte_in,
    output logic [7:0]  newer_byte,
    output logic [7:0]  middle_byte,
    output logic [7:0]  older_byte,
    output logic        window_full,
    output logic [11:0] table_index,
    output logic        index_valid
);
    byte_t [WIN_N-1:0] slots;
    logic              full;

    tri_byte_window u_win (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .din   (byte_in),
        .slots (slots),
        .full  (full)
    );

    tri_hash_stage u_hash (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .b_old    (slots[WIN_N-1]),
        .b_mid    (slots[1]),
        .b_new    (slots[0]),
        .win_full (full),
        .idx      (table_index),
        .idx_vld  (index_valid)
    );

    assign newer_byte  = slots[0];
    assign middle_byte = slots[1];
    assign older_byte  = slots[WIN_N-1];
    assign window_full = full;

    // R2: the window becomes full only at an enabled edge
    a_r2_full_on_enable: assert property (@(posedge clk) disable iff (rst)
        $rose(window_full) |-> $past(en));

    // R8: the first edge out of reset never reports a valid index
    a_r8_no_stale_valid: assert property (@(posedge clk)
        rst |=> !index_valid);
endmodule

// File: tb/sim_trigram_hash_unit.sv
`timescale 1ns/1ps
module sim_trigram_hash_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [7:0]  byte_in = 8'h00;
    logic [7:0]  newer_byte, middle_byte, older_byte;
    logic        window_full, index_valid;
    logic [11:0] table_index;

    trigram_hash_unit u0 (
        .clk         (clk),
        .rst         (rst),
        .en          (en),
        .byte_in     (byte_in),
        .newer_byte  (newer_byte),
        .middle_byte (middle_byte),
        .older_byte  (older_byte),
        .window_full (window_full),
        .table_index (table_index),
        .index_valid (index_valid)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int    b_new, b_mid, b_old;
        bit    full, vld;
        int    idx;
        string tag;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    int m_new = 0, m_mid = 0, m_old = 0, m_fill = 0, m_idx = 0;
    bit m_full = 0, m_vld = 0;

    function automatic int ref_hash(int o, int m, int n);
        longint x, p;
        x = longint'((o << 8) ^ (m << 4) ^ n);
        p = x * 40543;
        return int'((p >> 4) & 'hFFF);
    endfunction

    task automatic chk(string tag, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    // driver: predicts the outputs after the coming edge and queues them
    task automatic step(bit r, bit e, int b, string tag);
        exp_t x;
        @(negedge clk);
        rst = r; en = e; byte_in = 8'(b);
        if (r) begin
            m_new = 0; m_mid = 0; m_old = 0; m_fill = 0;
            m_full = 0; m_vld = 0; m_idx = 0;
        end else if (e) begin
            m_idx = ref_hash(m_old, m_mid, m_new);
            m_vld = m_full;
            m_old = m_mid; m_mid = m_new; m_new = b & 'hFF;
            if (m_fill < 3) m_fill++;
            m_full = (m_fill == 3);
        end else begin
            m_vld = 0;
        end
        x.b_new = m_new; x.b_mid = m_mid; x.b_old = m_old;
        x.full = m_full; x.vld = m_vld; x.idx = m_idx; x.tag = tag;
        q.push_back(x);
    endtask

    // monitor: compares after each edge
    always @(posedge clk) begin
        exp_t x;
        #1;
        if (q.size() > 0) begin
            x = q.pop_front();
            chk(x.tag, "newer_byte",  int'(newer_byte),  x.b_new);
            chk(x.tag, "middle_byte", int'(middle_byte), x.b_mid);
            chk(x.tag, "older_byte",  int'(older_byte),  x.b_old);
            chk(x.tag, "window_full", int'(window_full), int'(x.full));
            chk(x.tag, "index_valid", int'(index_valid), int'(x.vld));
            chk(x.tag, "table_index", int'(table_index), x.idx);
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R6: reset state
        step(1, 0, 8'h00, "R6");
        step(1, 1, 8'h5A, "R6");
        // R1 R2: filling the window
        step(0, 1, 8'h11, "R1");
        step(0, 1, 8'h22, "R2");
        step(0, 1, 8'h33, "R2");
        // R3 R4: stream of varied bytes
        step(0, 1, 8'h44, "R3");
        step(0, 1, 8'hA7, "R4");
        step(0, 1, 8'h00, "R4");
        step(0, 1, 8'h80, "R4");
        // R7: gaps of one and several cycles
        step(0, 0, 8'hEE, "R7");
        step(0, 1, 8'h3C, "R7");
        step(0, 0, 8'h99, "R7");
        step(0, 0, 8'h98, "R7");
        step(0, 0, 8'h97, "R7");
        step(0, 1, 8'hC3, "R7");
        // R5: high-value bytes
        for (int i = 0; i < 5; i++) step(0, 1, 8'hFF, "R5");
        step(0, 1, 8'hFE, "R5");
        step(0, 1, 8'hF0, "R5");
        step(0, 1, 8'h0F, "R5");
        // R8: reset after two bytes, then refill
        step(1, 0, 8'h00, "R8");
        step(0, 1, 8'h12, "R8");
        step(0, 1, 8'h34, "R8");
        step(1, 1, 8'h56, "R8");
        step(0, 1, 8'h78, "R8");
        step(0, 1, 8'h9A, "R8");
        step(0, 0, 8'hBC, "R8");
        step(0, 1, 8'hDE, "R8");
        step(0, 1, 8'hF1, "R8");
        // R4: pseudo-random run
        for (int i = 0; i < 60; i++) step(0, (i % 7) != 3, int'($urandom_range(0, 255)), "R4");
        step(0, 0, 8'h00, "R7");
        repeat (3) @(negedge clk);
        checks++;
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R3 queue: actual %0d expected 0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule